// File: doc/BRIEF.md
# Endpoint-Zero SETUP Capture Unit

This block sits between a packet-level USB receiver and a local CPU and takes care of the SETUP stage of control transfers on endpoint zero. The receiver gives it three strobes: one for a SETUP token, one for any other token addressed to endpoint zero, and one for end of packet. The end-of-packet strobe comes with a flag that says whether the CRC was good. Data bytes arrive as a byte stream with a valid qualifier. The unit keeps the eight request bytes in a buffer that the CPU can read. It raises two request flags that the CPU can either poll or take as an interrupt, and it chooses the handshake the receiver sends back.

SETUP is never refused. A new SETUP overwrites the buffer even if the CPU has not yet dealt with the previous one. The token flag gives the CPU early warning that this is about to happen. The CPU can stall endpoint zero or make it answer NAK. The stall clears itself when the next SETUP token arrives, so the next control transfer can always begin.

Top module: `ep0_setup_capture`

## Requirements
- R1: After reset, every readable register reads 0, `irq` is 0 and `hs_code` is 0 (no handshake).
- R2: The data bytes of a SETUP packet are stored in order of arrival and read back at CPU addresses 0 to 7. Bytes arriving outside a SETUP packet are not stored.
- R3: A `tok_setup` strobe sets request bit 0 (token warning) of the request register at address 8. The bit is visible from the cycle after the strobe.
- R4: A SETUP packet whose end-of-packet strobe comes with a good CRC after exactly eight bytes sets request bit 1 (data available). In the cycle after the end-of-packet strobe, `hs_code` is 1 (ACK).
- R5: A SETUP packet with a bad CRC, or with a byte count other than eight, does not set request bit 1. In the cycle after its end-of-packet strobe, `hs_code` is 0 (none).
- R6: A new SETUP is accepted while earlier request bits are still pending. It overwrites the buffer, sets the request bits again and is answered with ACK, never NAK.
- R7: Writing to address 8 clears each request bit written with 1 and leaves the bits written with 0 unchanged. A hardware set in the same cycle as a clear of that bit wins.
- R8: Address 9 holds one enable per request bit, in the same bit positions. `irq` is the OR of each request bit ANDed with its enable. Request bits still set, and can still be read, when their enables are 0.
- R9: Address 10 holds the stall bit (bit 0) and the handshake-NAK bit (bit 1). The cycle after a `tok_other` strobe, `hs_code` is 3 (STALL) if stall is set, otherwise 2 (NAK) if handshake-NAK is set, otherwise 1 (ACK). A good SETUP packet gets ACK even while stall is set.
- R10: A `tok_setup` strobe clears the stall bit in the following cycle, and this takes priority over a CPU write in the same cycle. The handshake-NAK bit is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_setup | input | 1 | One-cycle strobe: SETUP token received for endpoint zero |
| tok_other | input | 1 | One-cycle strobe: a non-SETUP token for endpoint zero that needs a handshake |
| rx_valid | input | 1 | Data byte valid |
| rx_data | input | 8 | Received data byte |
| rx_eop | input | 1 | End-of-packet strobe for the data packet |
| rx_crc_ok | input | 1 | CRC status, qualified by `rx_eop` |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 4 | CPU register address (read and write) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational from `cpu_addr` |
| irq | output | 1 | Combined interrupt request |
| hs_code | output | 2 | Handshake to send: 0 none, 1 ACK, 2 NAK, 3 STALL |

## Verification
The hardest case to reach is a collision in a single cycle: a CPU write-one-to-clear of the token bit in the same cycle as a fresh SETUP token, or a CPU write to the control register in the same cycle as the token clears the stall. The bench drives the token strobe and the CPU write on the same falling edge, so both are seen at the same rising edge. The bench also sends packets of seven and nine bytes and packets with a bad CRC, so that every way a packet can fail is shown to leave the data-available bit clear. It sends a second SETUP before the first has been serviced, with a different byte pattern, so that an overwrite cannot pass by chance.

// File: rtl/setup_cap_pkg.sv
// Package: shared handshake encoding and request-bit positions for the
// endpoint-zero SETUP capture unit. Assumes a two-bit handshake field.
package setup_cap_pkg;
    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    localparam int NUM_REQ = 2;
    localparam int REQ_TOK = 0;
    localparam int REQ_DAT = 1;
    localparam int CTL_STALL = 0;
    localparam int CTL_HSNAK = 1;
endpackage

// File: rtl/setup_buf.sv
// setup_buf: tracks one SETUP data packet, writes each valid byte into the
// slot given by its arrival index and judges the packet at end of packet.
// Assumes tok_setup precedes the data packet and that rx_eop closes it.
module setup_buf #(
    parameter int NBYTES = 8,
    parameter int DW     = 8,
    localparam int CNT_W = $clog2(NBYTES + 2),
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_setup,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_data,
    input  logic             rx_eop,
    input  logic             rx_crc_ok,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_byte,
    output logic             pkt_end,
    output logic             pkt_good
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBYTES);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(NBYTES + 1);

    logic             in_pkt;
    logic [CNT_W-1:0] cnt;
    logic [DW-1:0]    byte_q [NBYTES];

    // Packet window: opened by a SETUP token, closed by end of packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt <= 1'b0;
        end else if (tok_setup) begin
            in_pkt <= 1'b1;
        end else if (rx_eop) begin
            in_pkt <= 1'b0;
        end
    end

    // Byte counter: saturates one past full so that over-length packets are detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tok_setup) begin
            cnt <= '0;
        end else if (in_pkt && rx_valid && cnt != CNT_OVER) begin
            cnt <= cnt + 1'b1;
        end
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_slot
        // Byte slot i: takes the i-th byte of the current packet.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q[i] <= '0;
            end else if (in_pkt && rx_valid && !tok_setup && cnt == CNT_W'(i)) begin
                byte_q[i] <= rx_data;
            end
        end
    end

    assign rd_byte  = byte_q[rd_idx];
    assign pkt_end  = in_pkt && rx_eop && !tok_setup;
    assign pkt_good = pkt_end && rx_crc_ok && cnt == CNT_FULL;
endmodule

// File: rtl/irq_regs.sv
// irq_regs: request bits that hardware sets and the CPU clears by writing 1,
// their enables, and the combined interrupt. A hardware set beats a clear.
module irq_regs #(
    parameter int NREQ = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] set_evt,
    input  logic            wr_req,
    input  logic            wr_en,
    input  logic [NREQ-1:0] wdata,
    output logic [NREQ-1:0] req_q,
    output logic [NREQ-1:0] en_q,
    output logic            irq
);
    // Request bits: a clear from the CPU first, then hardware sets on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= (req_q & ~(wr_req ? wdata : '0)) | set_evt;
        end
    end

    // Enable register: written by the CPU only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wdata;
        end
    end

    assign irq = |(req_q & en_q);
endmodule

// File: rtl/ep0_hs.sv
// ep0_hs: endpoint-zero stall and handshake-NAK bits, and the registered
// handshake choice. A SETUP token clears the stall, and this beats a CPU write.
module ep0_hs
    import setup_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tok_setup,
    input  logic       tok_other,
    input  logic       pkt_end,
    input  logic       pkt_good,
    input  logic       wr_ctl,
    input  logic [1:0] wdata,
    output logic       stall_q,
    output logic       hsnak_q,
    output hs_e        hs_q
);
    // Stall bit: set by the CPU, cleared by the next SETUP token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
        end else if (tok_setup) begin
            stall_q <= 1'b0;
        end else if (wr_ctl) begin
            stall_q <= wdata[CTL_STALL];
        end
    end

    // Handshake-NAK bit: under CPU control only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsnak_q <= 1'b0;
        end else if (wr_ctl) begin
            hsnak_q <= wdata[CTL_HSNAK];
        end
    end

    // Handshake: SETUP data is judged on its own; other traffic follows stall, then NAK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= HS_NONE;
        end else if (pkt_end) begin
            hs_q <= pkt_good ? HS_ACK : HS_NONE;
        end else if (tok_other) begin
            hs_q <= stall_q ? HS_STALL : (hsnak_q ? HS_NAK : HS_ACK);
        end else begin
            hs_q <= HS_NONE;
        end
    end
endmodule

// File: rtl/ep0_setup_capture.sv
// ep0_setup_capture: top level. Decodes the CPU register port (addresses
// 0..NBYTES-1 are the SETUP bytes, followed by request, enable and control)
// and connects the buffer, the request logic and the handshake logic.
// Assumes the packet-level strobes are one cycle wide and use this clock.
module ep0_setup_capture
    import setup_cap_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int DW     = 8,
    parameter int AW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_setup,
    input  logic          tok_other,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_eop,
    input  logic          rx_crc_ok,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          irq,
    output logic [1:0]    hs_code
);
    localparam int IDX_W = $clog2(NBYTES);
    localparam logic [AW-1:0] A_REQ = AW'(NBYTES);
    localparam logic [AW-1:0] A_EN  = AW'(NBYTES + 1);
    localparam logic [AW-1:0] A_CTL = AW'(NBYTES + 2);

    logic [DW-1:0]      rd_byte;
    logic               pkt_end;
    logic               pkt_good;
    logic [NUM_REQ-1:0] req_q;
    logic [NUM_REQ-1:0] en_q;
    logic [NUM_REQ-1:0] set_evt;
    logic               stall_q;
    logic               hsnak_q;
    hs_e                hs_q;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^cpu_wdata[DW-1:NUM_REQ];

    setup_buf #(.NBYTES(NBYTES), .DW(DW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_setup (tok_setup),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_eop    (rx_eop),
        .rx_crc_ok (rx_crc_ok),
        .rd_idx    (cpu_addr[IDX_W-1:0]),
        .rd_byte   (rd_byte),
        .pkt_end   (pkt_end),
        .pkt_good  (pkt_good)
    );

    assign set_evt[REQ_TOK] = tok_setup;
    assign set_evt[REQ_DAT] = pkt_good;

    irq_regs #(.NREQ(NUM_REQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .wr_req  (cpu_wr && cpu_addr == A_REQ),
        .wr_en   (cpu_wr && cpu_addr == A_EN),
        .wdata   (cpu_wdata[NUM_REQ-1:0]),
        .req_q   (req_q),
        .en_q    (en_q),
        .irq     (irq)
    );

    ep0_hs u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_setup (tok_setup),
        .tok_other (tok_other),
        .pkt_end   (pkt_end),
        .pkt_good  (pkt_good),
        .wr_ctl    (cpu_wr && cpu_addr == A_CTL),
        .wdata     (cpu_wdata[1:0]),
        .stall_q   (stall_q),
        .hsnak_q   (hsnak_q),
        .hs_q      (hs_q)
    );

    assign hs_code = hs_q;

    // Read mux: SETUP bytes, then request, enable and control registers.
    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr < A_REQ) begin
            cpu_rdata = rd_byte;
        end else if (cpu_addr == A_REQ) begin
            cpu_rdata[NUM_REQ-1:0] = req_q;
        end else if (cpu_addr == A_EN) begin
            cpu_rdata[NUM_REQ-1:0] = en_q;
        end else if (cpu_addr == A_CTL) begin
            cpu_rdata[CTL_STALL] = stall_q;
            cpu_rdata[CTL_HSNAK] = hsnak_q;
        end
    end
endmodule

// File: rtl/ep0_setup_capture_chk.sv
// ep0_setup_capture_chk: protocol checks on the capture unit, attached by bind.
module ep0_setup_capture_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tok_setup,
    input logic       tok_other,
    input logic       pkt_end,
    input logic       pkt_good,
    input logic       cpu_wr,
    input logic [3:0] cpu_addr,
    input logic [7:0] cpu_wdata,
    input logic [1:0] req_q,
    input logic [1:0] en_q,
    input logic       stall_q,
    input logic       irq,
    input logic [1:0] hs_code
);
    assert_tok_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tok_setup |=> req_q[0]);

    assert_good_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_good |=> (req_q[1] && hs_code == 2'd1));

    assert_bad_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && !pkt_good) |=> hs_code == 2'd0);

    assert_no_nak_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> hs_code != 2'd2);

    assert_req_fall_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q[0]) |-> $past(cpu_wr && cpu_addr == 4'd8 && cpu_wdata[0]));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((req_q & en_q) != 2'b00));

    assert_stall_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_other && !pkt_end && stall_q) |=> hs_code == 2'd3);

    assert_stall_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tok_setup |=> !stall_q);
endmodule

bind ep0_setup_capture ep0_setup_capture_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_setup (tok_setup),
    .tok_other (tok_other),
    .pkt_end   (pkt_end),
    .pkt_good  (pkt_good),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .req_q     (req_q),
    .en_q      (en_q),
    .stall_q   (stall_q),
    .irq       (irq),
    .hs_code   (hs_code)
);

// File: tb/test_ep0_setup_capture.sv
// Directed bench for ep0_setup_capture: inputs are driven and outputs are sampled on falling edges.
module test_ep0_setup_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_setup = 1'b0, tok_other = 1'b0;
    logic       rx_valid = 1'b0, rx_eop = 1'b0, rx_crc_ok = 1'b0;
    logic [7:0] rx_data = '0;
    logic       cpu_wr = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       irq;
    logic [1:0] hs_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    ep0_setup_capture i_ep0_setup_capture (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        cpu_addr = a;
        #1;
        v = cpu_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // Send one SETUP: token, n bytes (base + index * step), end of packet; returns the handshake.
    task automatic send_setup(input int n, input logic [7:0] base, input logic [7:0] step,
                              input logic crc, output logic [1:0] hs);
        @(negedge clk);
        tok_setup = 1'b1;
        @(negedge clk);
        tok_setup = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = base + 8'(i) * step;
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_eop = 1'b1; rx_crc_ok = crc;
        @(negedge clk);
        rx_eop = 1'b0; rx_crc_ok = 1'b0;
        hs = hs_code;
    endtask

    task automatic chk_bytes(input string tag, input logic [7:0] base, input logic [7:0] step);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(4'(i), v);
            chk(tag, v, 8'(base + 8'(i) * step));
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 11; a++) begin
            rd(4'(a), v);
            chk("R1 reset register", v, 0);
        end
        chk("R1 reset irq", irq, 0);
        chk("R1 reset handshake", hs_code, 0);
    endtask

    task automatic t_basic();
        logic [1:0] hs;
        logic [7:0] v;
        // Stray bytes outside a packet must not land in the buffer.
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'hEE;
        @(negedge clk);
        rx_valid = 1'b0;
        rd(4'd0, v);
        chk("R2 stray byte ignored", v, 0);
        send_setup(8, 8'h10, 8'h11, 1'b1, hs);
        chk("R4 ACK on good packet", hs, 1);
        rd(4'd8, v);
        chk("R3 R4 request bits", v, 3);
        chk("R8 irq with enables off", irq, 0);
        chk_bytes("R2 byte order", 8'h10, 8'h11);
        @(negedge clk);
        chk("R4 handshake lasts one cycle", hs_code, 0);
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        wr(4'd8, 8'h00);
        rd(4'd8, v);
        chk("R7 write 0 keeps bits", v, 3);
        wr(4'd8, 8'h01);
        rd(4'd8, v);
        chk("R7 clear token bit", v, 2);
        wr(4'd8, 8'h02);
        rd(4'd8, v);
        chk("R7 clear data bit", v, 0);
    endtask

    task automatic t_irq();
        logic [1:0] hs;
        logic [7:0] v;
        wr(4'd9, 8'h02);
        rd(4'd9, v);
        chk("R8 enable readback", v, 2);
        chk("R8 irq idle", irq, 0);
        send_setup(8, 8'h01, 8'h01, 1'b1, hs);
        chk("R8 irq on data bit", irq, 1);
        wr(4'd8, 8'h02);
        rd(4'd8, v);
        chk("R8 token bit kept", v, 1);
        chk("R8 irq masked token", irq, 0);
        wr(4'd9, 8'h00);
        wr(4'd8, 8'h03);
    endtask

    task automatic t_bad();
        logic [1:0] hs;
        logic [7:0] v;
        send_setup(7, 8'h40, 8'h01, 1'b1, hs);
        chk("R5 short packet handshake", hs, 0);
        rd(4'd8, v);
        chk("R5 short packet bits", v, 1);
        wr(4'd8, 8'h01);
        send_setup(9, 8'h50, 8'h01, 1'b1, hs);
        chk("R5 long packet handshake", hs, 0);
        rd(4'd8, v);
        chk("R5 long packet bits", v, 1);
        wr(4'd8, 8'h01);
        send_setup(8, 8'h60, 8'h01, 1'b0, hs);
        chk("R5 bad CRC handshake", hs, 0);
        rd(4'd8, v);
        chk("R5 bad CRC bits", v, 1);
        wr(4'd8, 8'h01);
    endtask

    task automatic t_overwrite();
        logic [1:0] hs;
        logic [7:0] v;
        send_setup(8, 8'hA0, 8'h03, 1'b1, hs);
        send_setup(8, 8'h05, 8'h07, 1'b1, hs);
        chk("R6 second SETUP ACKed", hs, 1);
        rd(4'd8, v);
        chk("R6 bits set again", v, 3);
        chk_bytes("R6 buffer overwritten", 8'h05, 8'h07);
        wr(4'd8, 8'h03);
    endtask

    task automatic other_tok(output logic [1:0] hs);
        @(negedge clk);
        tok_other = 1'b1;
        @(negedge clk);
        tok_other = 1'b0;
        hs = hs_code;
    endtask

    task automatic t_stall();
        logic [1:0] hs;
        logic [7:0] v;
        wr(4'd10, 8'h01);
        other_tok(hs);
        chk("R9 STALL", hs, 3);
        wr(4'd10, 8'h02);
        other_tok(hs);
        chk("R9 NAK", hs, 2);
        wr(4'd10, 8'h03);
        other_tok(hs);
        chk("R9 STALL over NAK", hs, 3);
        wr(4'd10, 8'h00);
        other_tok(hs);
        chk("R9 ACK", hs, 1);
        wr(4'd10, 8'h03);
        send_setup(8, 8'h20, 8'h02, 1'b1, hs);
        chk("R9 SETUP ACK under stall", hs, 1);
        rd(4'd10, v);
        chk("R10 stall cleared, NAK kept", v, 2);
        wr(4'd8, 8'h03);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        logic [1:0] hs;
        send_setup(8, 8'h00, 8'h01, 1'b1, hs);
        // Token and token-bit clear meet at one edge.
        @(negedge clk);
        tok_setup = 1'b1; cpu_wr = 1'b1; cpu_addr = 4'd8; cpu_wdata = 8'h01;
        @(negedge clk);
        tok_setup = 1'b0; cpu_wr = 1'b0;
        rd(4'd8, v);
        chk("R7 set beats clear", v[0], 1);
        rx_eop = 1'b1; rx_crc_ok = 1'b0;
        @(negedge clk);
        rx_eop = 1'b0;
        // Token and a stall write meet at one edge.
        @(negedge clk);
        tok_setup = 1'b1; cpu_wr = 1'b1; cpu_addr = 4'd10; cpu_wdata = 8'h01;
        @(negedge clk);
        tok_setup = 1'b0; cpu_wr = 1'b0;
        rd(4'd10, v);
        chk("R10 token beats stall write", v[0], 0);
        rx_eop = 1'b1;
        @(negedge clk);
        rx_eop = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_w1c();
        t_irq();
        t_bad();
        t_overwrite();
        t_stall();
        t_collide();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule